// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a small word-addressed memory that threads use to hand data from producer to consumer. Each data word carries a one-bit tag that says whether the word is full or empty. A write stores its data and marks the word full. A read of a full word is answered straight away. A read of an empty word is neither refused nor answered with stale data. The read is accepted and parked in a bounded table of waiting readers, together with the requesting thread's ID. When a later write fills that word, every reader parked on the address is answered with the written data. The answers come one per cycle, in the order the reads arrived.

Requests enter on a single valid/ready port. Each request carries a write flag, an address, write data and a thread ID. Responses leave as a one-cycle pulse carrying the thread ID and the data. A clear input returns every word to the empty state in one clock. Reset does the same. Data contents are kept, but they can no longer be read until a new write arrives.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every word is empty. A read accepted then produces no response until some write fills that word.
- R2: A write accepted on a clock edge sets the word's tag to full. A read of a full word produces `rsp_valid` on the next edge, carrying the reader's `req_tid` and the stored data. The tag stays full, so repeated reads each get the data.
- R3: A write to a word that is already full replaces the data, and the tag stays full.
- R4: A read of an empty word is accepted (`req_ready` high while the table has room) and produces no response while the word stays empty.
- R5: A write to an address with parked readers answers each of those readers exactly once with the written data, one per cycle, oldest first. The first response appears on the second clock edge after the write is accepted. Readers parked on other addresses stay parked.
- R6: While parked readers are being answered, `req_ready` is low for every request.
- R7: The table holds `PEND_DEPTH` readers. When it is full, a read of an empty word sees `req_ready` low, while writes and reads of full words are still accepted.
- R8: While `clear_all` is high, `req_ready` is low. One edge of `clear_all` makes every word empty. Readers already parked stay parked.
- R9: Each accepted read yields at most one response, and at most one response is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; empties all words and the reader table |
| clear_all | input | 1 | Marks every word empty on the next edge |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_tid | input | TID_W | Requesting thread ID |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_tid | output | TID_W | Thread that the response answers |
| rsp_data | output | DATA_W | Data returned to that thread |

## Verification
The bench parks three readers on one address and a fourth on another, so the table is full, and then writes the shared address. A design that woke readers in the wrong order, answered the bystander, or answered one reader twice would show it in the exact per-cycle sequence of thread IDs. With the table full, the bench checks that reads of empty words stall while a write and a read of a full word still pass; a design that gated all traffic on table occupancy would deadlock the producer. Overwrite and clear are probed by reads afterwards: a design that ignored the second write would return the older data, and one that kept tags after a clear would answer the post-clear reads at once.

// File: rtl/fe_pkg.sv
package fe_pkg;

  // Source of the response registered in a cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HIT  = 2'd1,
    SRC_WAKE = 2'd2
  } rsp_src_e;

  // Index of the lowest set bit; 0 when no bit is set.
  function automatic int lowest_set(input logic [31:0] m);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // Pick the response source; waking readers outrank direct hits.
  function automatic rsp_src_e pick_src(input logic hit, input logic wake);
    if (wake) return SRC_WAKE;
    if (hit) return SRC_HIT;
    return SRC_NONE;
  endfunction

endpackage

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_full,
  output logic [DATA_W-1:0] q_data,
  input  logic [ADDR_W-1:0] d_addr,
  output logic [DATA_W-1:0] d_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  tag;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         tag <= '0;
    else if (clear_all) tag <= '0;
    else if (wr_en)     tag[wr_addr] <= 1'b1;
  end

  assign q_full = tag[q_addr];
  assign q_data = mem[q_addr];
  assign d_data = mem[d_addr];

  // R8
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (tag == '0));

  // R2
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear_all) |=> tag[$past(wr_addr)]);

  // R3
  write_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/fe_pend_table.sv
module fe_pend_table #(
  parameter int ADDR_W = 4,
  parameter int TID_W  = 4,
  parameter int N      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TID_W-1:0]  push_tid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              wake,
  input  logic [ADDR_W-1:0] wake_addr,
  input  logic              pop,
  output logic              full,
  output logic              any_woken,
  output logic [TID_W-1:0]  pop_tid,
  output logic [ADDR_W-1:0] pop_addr
);
  import fe_pkg::*;

  localparam int CW = $clog2(N + 1);

  // Entries kept packed in arrival order: index 0 is the oldest.
  logic [TID_W-1:0]  e_tid  [N];
  logic [ADDR_W-1:0] e_addr [N];
  logic [N-1:0]      e_vld;
  logic [N-1:0]      e_wok;

  logic [TID_W-1:0]  n_tid  [N];
  logic [ADDR_W-1:0] n_addr [N];
  logic [N-1:0]      n_vld;
  logic [N-1:0]      n_wok;

  logic [CW-1:0] cnt;
  int            oldest;

  assign cnt       = CW'($countones(e_vld));
  assign full      = e_vld[N-1];
  assign any_woken = |e_wok;
  assign oldest    = lowest_set(32'(e_wok));

  always_comb begin
    pop_tid  = '0;
    pop_addr = '0;
    for (int i = 0; i < N; i++) begin
      if (i == oldest) begin
        pop_tid  = e_tid[i];
        pop_addr = e_addr[i];
      end
    end
  end

  always_comb begin
    n_tid  = e_tid;
    n_addr = e_addr;
    n_vld  = e_vld;
    n_wok  = e_wok;
    if (pop) begin
      for (int i = 0; i < N; i++) begin
        if (i >= oldest) begin
          if (i < N - 1) begin
            n_tid[i]  = e_tid[i+1];
            n_addr[i] = e_addr[i+1];
            n_vld[i]  = e_vld[i+1];
            n_wok[i]  = e_wok[i+1];
          end else begin
            n_vld[i] = 1'b0;
            n_wok[i] = 1'b0;
          end
        end
      end
    end
    if (wake) begin
      for (int i = 0; i < N; i++) begin
        if (e_vld[i] && (e_addr[i] == wake_addr)) n_wok[i] = 1'b1;
      end
    end
    if (push) begin
      for (int i = 0; i < N; i++) begin
        if (i == int'(cnt)) begin
          n_tid[i]  = push_tid;
          n_addr[i] = push_addr;
          n_vld[i]  = 1'b1;
          n_wok[i]  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_wok <= '0;
      for (int i = 0; i < N; i++) begin
        e_tid[i]  <= '0;
        e_addr[i] <= '0;
      end
    end else begin
      e_vld  <= n_vld;
      e_wok  <= n_wok;
      e_tid  <= n_tid;
      e_addr <= n_addr;
    end
  end

  // R7
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, wake, pop}));

  // R5
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (cnt == $past(cnt) - CW'(1)));

  // R5
  pop_needs_woken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> any_woken);

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int TID_W      = 4,
  parameter int PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TID_W-1:0]  req_tid,
  output logic              rsp_valid,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [DATA_W-1:0] rsp_data
);
  import fe_pkg::*;

  logic              q_full;
  logic [DATA_W-1:0] q_data;
  logic [DATA_W-1:0] d_data;
  logic              tbl_full;
  logic              draining;
  logic [TID_W-1:0]  pop_tid;
  logic [ADDR_W-1:0] pop_addr;

  // Named request events.
  logic acc, wr_fire, hit_fire, park_fire, drain_fire;
  rsp_src_e src;

  assign req_ready  = !clear_all && !draining &&
                      (req_write || q_full || !tbl_full);
  assign acc        = req_valid && req_ready;
  assign wr_fire    = acc && req_write;
  assign hit_fire   = acc && !req_write && q_full;
  assign park_fire  = acc && !req_write && !q_full;
  assign drain_fire = draining;
  assign src        = pick_src(hit_fire, drain_fire);

  fe_tag_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .wr_en     (wr_fire),
    .wr_addr   (req_addr),
    .wr_data   (req_wdata),
    .q_addr    (req_addr),
    .q_full    (q_full),
    .q_data    (q_data),
    .d_addr    (pop_addr),
    .d_data    (d_data)
  );

  fe_pend_table #(.ADDR_W(ADDR_W), .TID_W(TID_W), .N(PEND_DEPTH)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (park_fire),
    .push_tid  (req_tid),
    .push_addr (req_addr),
    .wake      (wr_fire),
    .wake_addr (req_addr),
    .pop       (drain_fire),
    .full      (tbl_full),
    .any_woken (draining),
    .pop_tid   (pop_tid),
    .pop_addr  (pop_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tid   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (src != SRC_NONE);
      case (src)
        SRC_WAKE: begin
          rsp_tid  <= pop_tid;
          rsp_data <= d_data;
        end
        SRC_HIT: begin
          rsp_tid  <= req_tid;
          rsp_data <= q_data;
        end
        default: ;
      endcase
    end
  end

  // R6
  drain_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !req_ready);

  // R7
  full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_full && !req_write && !q_full) |-> !req_ready);

  // R8
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |-> !req_ready);

  // R2
  hit_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_valid && rsp_tid == $past(req_tid) && rsp_data == $past(q_data)));

  // R9
  single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_fire, drain_fire}));

endmodule

// File: tb/tb_fe_sync_mem.sv
module tb_fe_sync_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_all = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_tid = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_tid;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_rsp = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fe_sync_mem dut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tid(req_tid),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data)
  );

  always @(negedge clk) if (rsp_valid) n_rsp++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the next negedge.
  task automatic issue(input bit w, input int a, input int d, input int t, output bit acc);
    req_valid = 1'b1; req_write = w; req_addr = 4'(a);
    req_wdata = 16'(d); req_tid = 4'(t);
    #1 acc = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rsp(input string tag, input int t, input int d);
    chk(rsp_valid === 1'b1, {tag, " valid"}, int'(rsp_valid), 1);
    chk(rsp_tid == 4'(t), {tag, " tid"}, int'(rsp_tid), t);
    chk(rsp_data == 16'(d), {tag, " data"}, int'(rsp_data), d);
  endtask

  task automatic t_reset_state;
    bit a;
    chk(rsp_valid === 1'b0, "R1 no rsp after reset", int'(rsp_valid), 0);
    issue(0, 5, 0, 1, a);
    chk(a, "R4 empty read accepted", int'(a), 1);
    chk(rsp_valid === 1'b0, "R4 empty read parked", int'(rsp_valid), 0);
    idle(3);
    chk(rsp_valid === 1'b0, "R1 still no rsp", int'(rsp_valid), 0);
  endtask

  task automatic t_wake_order;
    bit a;
    issue(0, 5, 0, 2, a);
    issue(0, 6, 0, 3, a);
    issue(0, 5, 0, 4, a);
    chk(a, "R7 fourth park accepted", int'(a), 1);
    issue(0, 7, 0, 5, a);
    chk(!a, "R7 table full stalls empty read", int'(a), 0);
    issue(1, 9, 16'h0055, 0, a);
    chk(a, "R7 write accepted while full", int'(a), 1);
    issue(0, 9, 0, 6, a);
    chk(a, "R7 full-word read accepted while full", int'(a), 1);
    expect_rsp("R2 hit", 6, 16'h0055);
    issue(1, 5, 16'hA5A5, 0, a);
    chk(rsp_valid === 1'b0, "R5 no rsp one edge after write", int'(rsp_valid), 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd9; #1;
    chk(req_ready === 1'b0, "R6 ready low while draining", int'(req_ready), 0);
    req_valid = 1'b0;
    idle(1); expect_rsp("R5 first oldest", 1, 16'hA5A5);
    idle(1); expect_rsp("R5 second", 2, 16'hA5A5);
    idle(1); expect_rsp("R5 third", 4, 16'hA5A5);
    idle(1);
    chk(rsp_valid === 1'b0, "R5 bystander not answered", int'(rsp_valid), 0);
    issue(1, 6, 16'h0066, 0, a);
    idle(1); expect_rsp("R5 other address later", 3, 16'h0066);
  endtask

  task automatic t_overwrite;
    bit a;
    issue(1, 2, 16'h1111, 0, a);
    issue(1, 2, 16'h2222, 0, a);
    chk(a, "R3 overwrite accepted", int'(a), 1);
    issue(0, 2, 0, 9, a);
    expect_rsp("R3 newest data", 9, 16'h2222);
    issue(0, 2, 0, 10, a);
    expect_rsp("R2 tag stays full", 10, 16'h2222);
  endtask

  task automatic t_clear;
    bit a;
    issue(1, 8, 16'h0088, 0, a);
    clear_all = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd8; #1;
    chk(req_ready === 1'b0, "R8 ready low during clear", int'(req_ready), 0);
    req_valid = 1'b0;
    @(negedge clk); clear_all = 1'b0;
    issue(0, 8, 0, 7, a);
    chk(rsp_valid === 1'b0, "R8 cleared word parks", int'(rsp_valid), 0);
    issue(0, 9, 0, 8, a);
    chk(rsp_valid === 1'b0, "R8 second cleared word parks", int'(rsp_valid), 0);
    idle(2);
    chk(rsp_valid === 1'b0, "R8 parked readers wait", int'(rsp_valid), 0);
    issue(1, 8, 16'h0099, 0, a);
    idle(1); expect_rsp("R8 refill answers", 7, 16'h0099);
    idle(1);
    issue(1, 9, 16'h0777, 0, a);
    idle(1); expect_rsp("R8 refill second", 8, 16'h0777);
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_wake_order();
    t_overwrite();
    t_clear();
    chk(n_rsp == 9, "R9 total responses", n_rsp, 9);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule